// File: doc/BRIEF.md
# Fractional Audio Bit-Clock Divider

This block produces the serial bit clock of an audio port when the port drives its own clock. It divides the system clock by a ratio made of an integer part and a fraction in steps of 1/512. It then divides by a further fixed two, because each divided period is one half of the bit clock. This lets one fixed reference reach any sample rate from roughly 5.5 kHz up to 192 kHz.

Software chooses the two divisor fields so that the bit clock equals the sample rate times two channels times the sample width. The block gives two outputs:

- a toggling bit-clock level;
- a one-cycle enable pulse in the last system-clock cycle of every half period, for logic that shifts data in the system-clock domain.

When the port's bit clock comes from outside, the slave-mode input switches the divider off.

The fraction uses a 9-bit phase accumulator. At every half-period boundary the accumulator adds the fractional divisor. A carry out of the accumulator makes the next half period one system-clock cycle longer. On average, a half period lasts integer + fraction/512 cycles.

Top module: `bclk_frac_div`

## Requirements
- R1: After synchronous active-low reset, `bclk_o` and `tick_o` are 0, the clock enable is clear, and no pulse appears until the enable is written.
- R2: A write with `wr_sel`=1 stores the integer divisor N from `wr_data[9:0]`. A write with `wr_sel`=0 stores the fraction F from `wr_data[8:0]` and the clock enable from `wr_data[31]`. Once enabled, half period k lasts N+c_k cycles, where c_k is the carry out of the 9-bit sum acc+F, and acc starts at 0 and keeps the low 9 bits of each sum.
- R3: `tick_o` is high for exactly the last cycle of each half period. `bclk_o` starts low, inverts on the clock edge that ends a cycle with `tick_o` high, and holds its level otherwise.
- R4: A divisor write while the clock runs does not change the half period in progress. It takes effect at the next half-period boundary.
- R5: While the integer divisor is 0, the divider is off even with the enable set: no pulses, and `bclk_o` stays low.
- R6: `slave_i` high clears the stored clock enable one cycle later and keeps the divider off. After `slave_i` falls, the divider stays off until the enable is written again.
- R7: Clearing the enable parks `bclk_o` low within one cycle, stops the pulses, and resets the accumulator. After re-enabling, the half-period sequence starts again from accumulator 0.
- R8: Over 512 consecutive half periods, the total length is exactly 512·N + F system-clock cycles, so the output frequency is f_in / (2·(N + F/512)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (reference) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 fraction/enable, 1 integer divisor |
| wr_data | input | 32 | Write data |
| slave_i | input | 1 | Port takes its bit clock from outside; forces the divider off |
| tick_o | output | 1 | One-cycle pulse in the last cycle of each half period |
| bclk_o | output | 1 | Bit-clock level |

## Verification
If the phase accumulator holds a wrong value, a half period comes out one cycle too long or too short. That shows at the ports as a wrong spacing between two pulses, at the latest within one full 512-step accumulator cycle; for most fractions it shows within a few half periods. If the down-counter holds a wrong value or its load comes too early, the very next interval between pulses is wrong. If the output flop is wrong, the bit-clock level seen at the next pulse is inverted, and every following pulse shows it too. A stale enable or run state shows as pulses during a window where the divider must be silent, or as a high bit clock after a disable.

// File: rtl/bclk_div_pkg.sv
// Package: shared widths and register selectors for the fractional
// bit-clock divider. Assumes a 32-bit write data path.
package bclk_div_pkg;
    localparam int DEF_INT_W  = 10;  // integer divisor width
    localparam int DEF_FRAC_W = 9;   // fractional divisor width (1/512 steps)
    localparam int DEF_DATA_W = 32;  // register write width
    localparam int DEF_EN_POS = 31;  // clock-enable bit in the fraction register

    typedef enum logic {
        SEL_FRAC = 1'b0,   // fraction + clock enable
        SEL_INT  = 1'b1    // integer divisor
    } reg_sel_e;
endpackage

// File: rtl/bclk_div_regs.sv
// Register bank: holds the integer divisor, the fraction and the clock
// enable. Slave mode has priority over a write and clears the enable.
// Assumes a one-cycle write strobe; no read-back path.
module bclk_div_regs
    import bclk_div_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int EN_POS = DEF_EN_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              slave_i,
    output logic [INT_W-1:0]  cfg_int,
    output logic [FRAC_W-1:0] cfg_frac,
    output logic              cfg_en
);
    logic hit_int;
    logic hit_frac;

    // Decode which register a write addresses.
    always_comb begin
        hit_int  = wr_en && (reg_sel_e'(wr_sel) == SEL_INT);
        hit_frac = wr_en && (reg_sel_e'(wr_sel) == SEL_FRAC);
    end

    // Store the divisors; slave mode wins over a write and clears the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_int  <= '0;
            cfg_frac <= '0;
            cfg_en   <= 1'b0;
        end else begin
            if (hit_int) begin
                cfg_int <= wr_data[INT_W-1:0];
            end
            if (hit_frac) begin
                cfg_frac <= wr_data[FRAC_W-1:0];
                cfg_en   <= wr_data[EN_POS];
            end
            if (slave_i) begin
                cfg_en <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bclk_div_step.sv
// Step logic: from the current accumulator and the programmed divisors,
// forms the next accumulator value and the length (minus one) of the next
// half period. Pure combinational. Assumes the integer divisor is non-zero
// whenever its result is used.
module bclk_div_step #(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 9,
    localparam int CNT_W = INT_W + 1
) (
    input  logic [FRAC_W-1:0] acc_q,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic [INT_W-1:0]  cfg_int,
    output logic [FRAC_W-1:0] acc_nxt,
    output logic [CNT_W-1:0]  len_m1
);
    logic [FRAC_W:0] sum;
    logic            carry;

    // Add the fraction; a carry stretches the next half period by one cycle.
    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, cfg_frac};
        carry   = sum[FRAC_W];
        acc_nxt = sum[FRAC_W-1:0];
        len_m1  = CNT_W'(cfg_int) - CNT_W'(1) + CNT_W'(carry);
    end
endmodule

// File: rtl/bclk_div_ctr.sv
// Half-period engine: counts each half period down, pulses in its last
// cycle, toggles the bit clock at the boundary and loads the next length
// and accumulator there. Clears everything when not allowed to run.
module bclk_div_ctr #(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 9,
    localparam int CNT_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  len_m1,
    input  logic [FRAC_W-1:0] acc_nxt,
    output logic [FRAC_W-1:0] acc_q,
    output logic              tick_o,
    output logic              bclk_o
);
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    // Last cycle of the current half period.
    always_comb begin
        tick_o = run_q && (cnt_q == '0);
    end

    // Sequence the half periods; park low and clear the phase when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            acc_q  <= '0;
            bclk_o <= 1'b0;
        end else if (!run_q) begin
            run_q <= 1'b1;
            cnt_q <= len_m1;
            acc_q <= acc_nxt;
        end else if (cnt_q == '0) begin
            bclk_o <= ~bclk_o;
            cnt_q  <= len_m1;
            acc_q  <= acc_nxt;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/bclk_frac_div.sv
// Top: fractional bit-clock divider. Output frequency is
// f_in / (2 * (N + F/2^FRAC_W)). Runs only while enabled, not in slave
// mode and with a non-zero integer divisor.
module bclk_frac_div
    import bclk_div_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int EN_POS = DEF_EN_POS,
    localparam int CNT_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              slave_i,
    output logic              tick_o,
    output logic              bclk_o
);
    logic [INT_W-1:0]  cfg_int;
    logic [FRAC_W-1:0] cfg_frac;
    logic              cfg_en;
    logic              cfg_go;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_nxt;
    logic [CNT_W-1:0]  len_m1;

    bclk_div_regs #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .EN_POS(EN_POS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .slave_i(slave_i),
        .cfg_int(cfg_int), .cfg_frac(cfg_frac), .cfg_en(cfg_en)
    );

    // Divider may run only when enabled, master mode, non-zero integer.
    always_comb begin
        cfg_go = cfg_en && !slave_i && (cfg_int != '0);
    end

    bclk_div_step #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_step (
        .acc_q(acc_q), .cfg_frac(cfg_frac), .cfg_int(cfg_int),
        .acc_nxt(acc_nxt), .len_m1(len_m1)
    );

    bclk_div_ctr #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .go(cfg_go), .len_m1(len_m1),
        .acc_nxt(acc_nxt), .acc_q(acc_q), .tick_o(tick_o), .bclk_o(bclk_o)
    );
endmodule

// File: rtl/bclk_div_chk.sv
// Checker: temporal properties of the divider, bound to the top module.
module bclk_div_chk #(
    parameter int INT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slave_i,
    input logic             cfg_en,
    input logic             cfg_go,
    input logic [INT_W-1:0] cfg_int,
    input logic             tick_o,
    input logic             bclk_o
);
    p_slave_clears_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slave_i |=> !cfg_en);

    p_park_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_go |=> (!bclk_o && !tick_o));

    p_int_zero_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_int == '0) |=> !tick_o);

    p_toggle_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && cfg_go) |=> (bclk_o != $past(bclk_o)));

    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && cfg_go) |=> $stable(bclk_o));
endmodule

bind bclk_frac_div bclk_div_chk #(.INT_W(INT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .slave_i(slave_i), .cfg_en(cfg_en),
    .cfg_go(cfg_go), .cfg_int(cfg_int), .tick_o(tick_o), .bclk_o(bclk_o)
);

// File: tb/tb_bclk_frac_div.sv
`timescale 1ns/1ps
module tb_bclk_frac_div;
    localparam int FRAC_MOD = 512;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        wr_sel;
    logic [31:0] wr_data;
    logic        slave_i;
    logic        tick_o;
    logic        bclk_o;

    always #2.5 clk = ~clk;

    bclk_frac_div dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .slave_i(slave_i), .tick_o(tick_o), .bclk_o(bclk_o)
    );

    typedef struct {
        int    len;   // expected spacing from previous pulse; 0 = unchecked
        bit    lvl;   // expected bit-clock level during the pulse
        string req;
    } exp_t;

    exp_t   q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     chk_on = 0;
    longint cyc = 0;
    longint last_tick = 0;
    longint first_tick = 0;
    int     tick_count = 0;
    event   ev_tick;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pop one expected item per pulse and compare spacing and level.
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (tick_o) begin
            tick_count++;
            if (chk_on && q.size() > 0) begin
                e = q.pop_front();
                if (e.len > 0)
                    check((cyc - last_tick) == e.len, e.req, "half-period length",
                          cyc - last_tick, e.len);
                else
                    first_tick = cyc;
                check(bclk_o == e.lvl, e.req, "bclk level at pulse", bclk_o, e.lvl);
            end
            last_tick = cyc;
            -> ev_tick;
        end
    end

    task automatic write_reg(bit sel, logic [31:0] d);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic write_frac(int f, bit en);
        logic [31:0] d;
        d      = '0;
        d[8:0] = f[8:0];
        d[31]  = en;
        write_reg(1'b0, d);
    endtask

    // Driver: compute expected half periods from the accumulator model.
    task automatic push_seq(int n, int f, int k, string req);
        int acc;
        int s;
        int l;
        bit lvl;
        acc = 0;
        lvl = 0;
        for (int i = 0; i < k; i++) begin
            s   = acc + f;
            l   = n + ((s >= FRAC_MOD) ? 1 : 0);
            acc = s % FRAC_MOD;
            q.push_back('{(i == 0) ? 0 : l, lvl, req});
            lvl = ~lvl;
        end
    endtask

    task automatic drain_and_stop();
        while (q.size() > 0) @(negedge clk);
        chk_on = 0;
        write_frac(0, 1'b0);
        repeat (3) @(negedge clk);
        q.delete();
    endtask

    task automatic run_seg(int n, int f, int k, string req);
        push_seq(n, f, k, req);
        chk_on = 1;
        write_reg(1'b1, 32'(n));
        write_frac(f, 1'b1);
        drain_and_stop();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int t0;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_sel  = 1'b0;
        wr_data = '0;
        slave_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and silence before any enable
        check(bclk_o == 1'b0, "R1", "bclk after reset", bclk_o, 0);
        check(tick_o == 1'b0, "R1", "tick after reset", tick_o, 0);
        write_reg(1'b1, 32'd3);
        t0 = tick_count;
        repeat (30) @(negedge clk);
        check(tick_count == t0, "R1", "pulses without enable", tick_count - t0, 0);

        // R2, R3: integer and fractional ratios, several patterns
        run_seg(4, 0, 10, "R2");
        run_seg(5, 128, 20, "R2");
        run_seg(2, 511, 30, "R3");
        run_seg(1, 256, 20, "R2");
        run_seg(1023, 1, 3, "R2");

        // R8: one full accumulator cycle of 512 half periods
        run_seg(3, 77, 513, "R8");
        check((last_tick - first_tick) == 512 * 3 + 77, "R8", "512 half periods total",
              last_tick - first_tick, 512 * 3 + 77);

        // R7: restart begins from accumulator zero
        run_seg(5, 300, 12, "R7");
        run_seg(5, 300, 12, "R7");

        // R7: clearing enable parks bclk low and stops pulses
        write_reg(1'b1, 32'd6);
        write_frac(100, 1'b1);
        while (bclk_o !== 1'b1) @(negedge clk);
        write_frac(100, 1'b0);
        @(negedge clk);
        check(bclk_o == 1'b0, "R7", "bclk after disable", bclk_o, 0);
        t0 = tick_count;
        repeat (50) @(negedge clk);
        check(tick_count == t0, "R7", "pulses after disable", tick_count - t0, 0);

        // R4: a write mid-run changes only the half periods after the boundary
        q.push_back('{0, 1'b0, "R4"});
        q.push_back('{5, 1'b1, "R4"});
        q.push_back('{5, 1'b0, "R4"});
        q.push_back('{5, 1'b1, "R4"});
        q.push_back('{8, 1'b0, "R4"});
        q.push_back('{8, 1'b1, "R4"});
        chk_on = 1;
        write_reg(1'b1, 32'd5);
        write_frac(0, 1'b1);
        repeat (3) @(ev_tick);
        write_reg(1'b1, 32'd8);
        drain_and_stop();

        // R5: integer divisor of zero keeps the divider off
        write_reg(1'b1, 32'd0);
        write_frac(200, 1'b1);
        t0 = tick_count;
        repeat (100) @(negedge clk);
        check(tick_count == t0, "R5", "pulses with zero integer", tick_count - t0, 0);
        check(bclk_o == 1'b0, "R5", "bclk with zero integer", bclk_o, 0);
        write_frac(0, 1'b0);

        // R6: slave mode clears the enable, which stays cleared afterwards
        write_reg(1'b1, 32'd4);
        slave_i = 1'b1;
        write_frac(0, 1'b1);
        t0 = tick_count;
        repeat (50) @(negedge clk);
        check(tick_count == t0, "R6", "pulses in slave mode", tick_count - t0, 0);
        slave_i = 1'b0;
        repeat (50) @(negedge clk);
        check(tick_count == t0, "R6", "pulses after slave release", tick_count - t0, 0);
        check(bclk_o == 1'b0, "R6", "bclk after slave release", bclk_o, 0);
        write_frac(0, 1'b1);
        repeat (30) @(negedge clk);
        check(tick_count > t0, "R6", "pulses after re-enable", tick_count - t0, 7);
        write_frac(0, 1'b0);
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end
endmodule